// File: doc/BRIEF.md
# Palette Table Fill Controller

This controller copies a 256-entry palette of 32-bit colours from video memory into an on-chip lookup table. A texture-register commit pulse arms it. The pulse comes with five fields: a base pointer, a pixel-format code, a storage-mode bit, a start offset and a load-control code. When the fields call for a full reload of a 32-bit palette, the controller steps an index from 0 to 255, one entry per clock. For each index it presents a byte address on a video memory read port and writes the returned word into the table at that index.

Two storage layouts are supported. In the linear layout, entry i sits at the word with byte offset 4·i above the base. In the grid layout, the eight index bits are split into a block, a row and a column. The grid layout is built only when a build-time parameter enables it. Without that parameter, a request for the grid layout is treated as no load.

Top module: `pal_fill_ctrl`

## Requirements
- R1: While `rst_ni` is low, `busy_o` and `tbl_we_o` are 0 and `tbl_idx_o` is 0. Asserting reset in the middle of a load clears these at once.
- R2: A load is accepted on a clock edge where `commit_i` is 1 with `fmt_i` = 0 (32-bit entries), `ctrl_i` = 1 (full reload) and a storage mode that is allowed. `busy_o` stays 0 in the cycle the pulse is presented. From the next cycle, `busy_o` is 1 and `tbl_idx_o` is 0.
- R3: A load issues exactly 256 table writes, one per cycle, at indexes 0,1,…,255 in ascending order. `busy_o` is high for exactly those 256 cycles and drops after index 255.
- R4: With `mode_i` = 1 (linear), the read address for index i is base_i·256 + 4·i. The word written at index i is the `rd_data_i` value present in that same cycle.
- R5: With `mode_i` = 0 and `GRID_EN` = 1, the read address for index i is base_i·256 + {i[7],i[3]}·256 + i[6:4]·32 + i[2:0]·4.
- R6: With `GRID_EN` = 0, a commit with `mode_i` = 0 starts no load: `busy_o` and `tbl_we_o` stay 0.
- R7: A commit with `ctrl_i` other than 1 starts no load.
- R8: A commit with `fmt_i` other than 0 starts no load.
- R9: A commit that arrives while a load is running is ignored. The running load continues with its original base and mode, and does not restart or add writes.
- R10: `start_i` has no effect on the addresses or data of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_i | input | 1 | Single-cycle texture-register commit pulse |
| base_i | input | BASE_W | Palette base pointer, in 256-byte units |
| fmt_i | input | 4 | Pixel-format code; 0 selects 32-bit entries |
| mode_i | input | 1 | Storage mode: 1 linear, 0 grid |
| start_i | input | 5 | Start offset (not used by full loads) |
| ctrl_i | input | 3 | Load-control code; 1 requests a full reload |
| rd_addr_o | output | ADDR_W | Byte address to video memory |
| rd_data_i | input | DATA_W | Video memory word, combinational from rd_addr_o |
| tbl_we_o | output | 1 | Table write enable |
| tbl_idx_o | output | 8 | Table write index |
| tbl_data_o | output | DATA_W | Table write data |
| busy_o | output | 1 | Load in progress |

## Verification
The bench fills video memory with a distinct word per location. It then checks every table entry against the location its layout formula selects. For the grid layout, a design that read linearly would store the wrong word at most indexes, so the grid check would fail. Two instances, one per `GRID_EN` value, share the grid commit. A build that ignored the parameter would load on the disabled instance. The bench also covers these cases: a second commit mid-load, which would restart the index or switch base if it were accepted; bad format and control codes, which would start a load if not decoded; a nonzero start offset, which would shift entries if it were wrongly applied; and a reset mid-load, which would leave busy stuck high if it did not clear the state.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned ENTRIES = 1 << IDX_W;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_DONE} pal_st_e;

  localparam logic [3:0] FMT_C32   = 4'd0;
  localparam logic [2:0] CTL_FULL  = 3'd1;
  localparam logic       MODE_GRID = 1'b0;
  localparam logic       MODE_LIN  = 1'b1;
endpackage

// File: rtl/pal_trig_dec.sv
module pal_trig_dec
  import pal_pkg::*;
#(
  parameter bit GRID_EN = 1'b1
) (
  input  logic       commit_i,
  input  logic [3:0] fmt_i,
  input  logic       mode_i,
  input  logic [2:0] ctrl_i,
  output logic       go_o
);
  logic mode_ok;

  generate
    if (GRID_EN) begin : g_both
      assign mode_ok = 1'b1;
    end else begin : g_lin_only
      assign mode_ok = (mode_i == MODE_LIN);
    end
  endgenerate

  assign go_o = commit_i && (fmt_i == FMT_C32) && (ctrl_i == CTL_FULL) && mode_ok;
endmodule

// File: rtl/pal_addr_gen.sv
module pal_addr_gen
  import pal_pkg::*;
#(
  parameter bit          GRID_EN = 1'b1,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned BASE_W  = 14,
  parameter int unsigned BLK_LSB = 8
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic              mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned OFF_W = IDX_W + 2;

  logic [OFF_W-1:0]  lin_off;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] base_byte;

  assign lin_off   = {idx_i, 2'b00};
  assign base_byte = ADDR_W'({base_i, {BLK_LSB{1'b0}}});

  generate
    if (GRID_EN) begin : g_grid
      logic [OFF_W-1:0] grid_off;
      // block {i7,i3}, row i[6:4], column i[2:0]; fields are disjoint so a concat is the sum
      assign grid_off = {idx_i[7], idx_i[3], idx_i[6:4], idx_i[2:0], 2'b00};
      assign off      = (mode_i == MODE_GRID) ? grid_off : lin_off;
    end else begin : g_lin
      logic unused_mode;
      assign unused_mode = mode_i;
      assign off         = lin_off;
    end
  endgenerate

  assign addr_o = base_byte + ADDR_W'(off);
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int unsigned BASE_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              mode_i,
  output logic [BASE_W-1:0] base_o,
  output logic              mode_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              busy_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ENTRIES - 1);

  pal_st_e           st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BASE_W-1:0] base_q;
  logic              mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      base_q <= '0;
      mode_q <= MODE_LIN;
    end else begin
      case (st_q)
        ST_IDLE: if (go_i) begin
          st_q   <= ST_LOAD;
          idx_q  <= '0;
          base_q <= base_i;
          mode_q <= mode_i;
        end
        ST_LOAD: begin
          if (idx_q == IDX_LAST) begin
            st_q  <= ST_DONE;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == ST_LOAD);
  assign idx_o  = idx_q;
  assign base_o = base_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/pal_fill_ctrl.sv
module pal_fill_ctrl
  import pal_pkg::*;
#(
  parameter bit          GRID_EN = 1'b1,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BASE_W  = 14,
  parameter int unsigned BLK_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [3:0]        fmt_i,
  input  logic              mode_i,
  input  logic [4:0]        start_i,
  input  logic [2:0]        ctrl_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              tbl_we_o,
  output logic [IDX_W-1:0]  tbl_idx_o,
  output logic [DATA_W-1:0] tbl_data_o,
  output logic              busy_o
);
  logic              go;
  logic [BASE_W-1:0] base_q;
  logic              mode_q;
  logic [IDX_W-1:0]  idx;
  logic              busy;
  logic [4:0]        unused_start;

  // full loads always begin at entry 0
  assign unused_start = start_i;

  pal_trig_dec #(.GRID_EN(GRID_EN)) u_dec (
    .commit_i (commit_i),
    .fmt_i    (fmt_i),
    .mode_i   (mode_i),
    .ctrl_i   (ctrl_i),
    .go_o     (go)
  );

  pal_seq #(.BASE_W(BASE_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .base_i (base_i),
    .mode_i (mode_i),
    .base_o (base_q),
    .mode_o (mode_q),
    .idx_o  (idx),
    .busy_o (busy)
  );

  pal_addr_gen #(
    .GRID_EN (GRID_EN),
    .ADDR_W  (ADDR_W),
    .BASE_W  (BASE_W),
    .BLK_LSB (BLK_LSB)
  ) u_addr (
    .base_i (base_q),
    .mode_i (mode_q),
    .idx_i  (idx),
    .addr_o (rd_addr_o)
  );

  assign tbl_we_o   = busy;
  assign tbl_idx_o  = idx;
  assign tbl_data_o = rd_data_i;
  assign busy_o     = busy;
endmodule

// File: rtl/pal_fill_chk.sv
module pal_fill_chk
  import pal_pkg::*;
#(
  parameter bit          GRID_EN = 1'b1,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BASE_W  = 14,
  parameter int unsigned BLK_LSB = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit_i,
  input logic [BASE_W-1:0] base_i,
  input logic [3:0]        fmt_i,
  input logic              mode_i,
  input logic [2:0]        ctrl_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              tbl_we_o,
  input logic [IDX_W-1:0]  tbl_idx_o,
  input logic [DATA_W-1:0] tbl_data_o,
  input logic              busy_o
);
  p_start_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (tbl_idx_o == '0) && $past(commit_i));

  p_idx_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (tbl_idx_o == IDX_W'($past(tbl_idx_o) + 1'b1)));

  p_end_after_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tbl_idx_o == IDX_W'(ENTRIES - 1)) |=> !busy_o);

  p_write_in_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_o |-> busy_o);

  p_data_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_o |-> (tbl_data_o == rd_data_i));

  p_lin_first_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && $past(mode_i) == MODE_LIN) |->
      (rd_addr_o == ADDR_W'({$past(base_i), {BLK_LSB{1'b0}}})));

  p_grid_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!GRID_EN && !busy_o && commit_i && mode_i == MODE_GRID) |=> !busy_o);

  p_bad_ctrl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && commit_i && ctrl_i != CTL_FULL) |=> !busy_o);

  p_bad_fmt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && commit_i && fmt_i != FMT_C32) |=> !busy_o);
endmodule

bind pal_fill_ctrl pal_fill_chk #(
  .GRID_EN (GRID_EN),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .BASE_W  (BASE_W),
  .BLK_LSB (BLK_LSB)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .commit_i   (commit_i),
  .base_i     (base_i),
  .fmt_i      (fmt_i),
  .mode_i     (mode_i),
  .ctrl_i     (ctrl_i),
  .rd_addr_o  (rd_addr_o),
  .rd_data_i  (rd_data_i),
  .tbl_we_o   (tbl_we_o),
  .tbl_idx_o  (tbl_idx_o),
  .tbl_data_o (tbl_data_o),
  .busy_o     (busy_o)
);

// File: tb/sim_pal_fill_ctrl.sv
`timescale 1ns/1ps
module sim_pal_fill_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic        commit = 1'b0;
  logic [13:0] base = '0;
  logic [3:0]  fmt = '0;
  logic        mode = 1'b1;
  logic [4:0]  start = '0;
  logic [2:0]  ctrl = 3'd1;

  logic [31:0] a0, a1, d0, d1;
  logic        we0, we1, busy0, busy1;
  logic [7:0]  idx0, idx1;

  logic [31:0] vram [0:1023];
  assign d0 = vram[a0[11:2]];
  assign d1 = vram[a1[11:2]];

  pal_fill_ctrl #(.GRID_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .commit_i(commit), .base_i(base), .fmt_i(fmt),
    .mode_i(mode), .start_i(start), .ctrl_i(ctrl), .rd_addr_o(a0), .rd_data_i(d0),
    .tbl_we_o(we0), .tbl_idx_o(idx0), .tbl_data_o(), .busy_o(busy0));

  pal_fill_ctrl #(.GRID_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .commit_i(commit), .base_i(base), .fmt_i(fmt),
    .mode_i(mode), .start_i(start), .ctrl_i(ctrl), .rd_addr_o(a1), .rd_data_i(d1),
    .tbl_we_o(we1), .tbl_idx_o(idx1), .tbl_data_o(), .busy_o(busy1));

  // u0 table data is observed through its own output port
  logic [31:0] td0;
  assign td0 = u0.tbl_data_o;

  int checks = 0, fails = 0;
  logic [31:0] got [0:255];
  int wcnt0 = 0, bcnt0 = 0, seq_err = 0, exp_next = 0;
  int wcnt1 = 0, bcnt1 = 0;

  always @(negedge clk) begin
    if (we0) begin
      if (int'(idx0) != exp_next) seq_err = seq_err + 1;
      exp_next = int'(idx0) + 1;
      got[idx0] = td0;
      wcnt0 = wcnt0 + 1;
    end
    if (busy0) bcnt0 = bcnt0 + 1;
    if (we1) wcnt1 = wcnt1 + 1;
    if (busy1) bcnt1 = bcnt1 + 1;
  end

  function automatic int grid_off(input int i);
    int b7 = (i >> 7) & 1, b3 = (i >> 3) & 1;
    return (b7 * 2 + b3) * 256 + ((i >> 4) & 7) * 32 + (i & 7) * 4;
  endfunction

  function automatic logic [31:0] exp_word(input int b, input bit lin, input int i);
    int off = lin ? i * 4 : grid_off(i);
    return vram[(b * 256 + off) >> 2];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    wcnt0 = 0; bcnt0 = 0; seq_err = 0; exp_next = 0; wcnt1 = 0; bcnt1 = 0;
    for (int i = 0; i < 256; i++) got[i] = '0;
  endtask

  task automatic fire(input int b, input logic [3:0] f, input bit m,
                      input logic [4:0] s, input logic [2:0] c);
    @(negedge clk);
    base = 14'(b); fmt = f; mode = m; start = s; ctrl = c; commit = 1'b1;
    chk(busy0 == 1'b0, "R2 busy low in commit cycle", busy0, 0);
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic verify(input int b, input bit lin, input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (got[i] !== exp_word(b, lin, i)) bad++;
    chk(bad == 0, req, bad, 0);
    chk(wcnt0 == 256, "R3 write count", wcnt0, 256);
    chk(bcnt0 == 256, "R3 busy cycles", bcnt0, 256);
    chk(seq_err == 0, "R3 index order", seq_err, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy0 == 0 && we0 == 0 && idx0 == 0, "R1 reset state", {busy0, we0, idx0}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_linear(input int b);
    clr();
    fire(b, 4'd0, 1'b1, 5'd0, 3'd1);
    chk(busy0 == 1 && idx0 == 0, "R2 load start", {busy0, idx0}, 9'h100);
    repeat (300) @(negedge clk);
    verify(b, 1'b1, "R4 linear data");
  endtask

  task automatic t_grid(input int b);
    clr();
    fire(b, 4'd0, 1'b0, 5'd0, 3'd1);
    repeat (300) @(negedge clk);
    verify(b, 1'b0, "R5 grid data");
    chk(wcnt1 == 0 && bcnt1 == 0, "R6 grid disabled no load", wcnt1 + bcnt1, 0);
  endtask

  task automatic t_bad_ctrl();
    clr();
    fire(0, 4'd0, 1'b1, 5'd0, 3'd0);
    fire(0, 4'd0, 1'b1, 5'd0, 3'd2);
    repeat (5) @(negedge clk);
    chk(wcnt0 == 0 && bcnt0 == 0, "R7 ctrl not full", wcnt0 + bcnt0, 0);
  endtask

  task automatic t_bad_fmt();
    clr();
    fire(0, 4'd2, 1'b1, 5'd0, 3'd1);
    fire(0, 4'd10, 1'b0, 5'd0, 3'd1);
    repeat (5) @(negedge clk);
    chk(wcnt0 == 0 && bcnt0 == 0, "R8 non-32bit format", wcnt0 + bcnt0, 0);
  endtask

  task automatic t_retrigger();
    clr();
    fire(1, 4'd0, 1'b1, 5'd0, 3'd1);
    repeat (20) @(negedge clk);
    base = 14'd3; mode = 1'b0; commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    repeat (300) @(negedge clk);
    verify(1, 1'b1, "R9 retrigger ignored");
  endtask

  task automatic t_start();
    clr();
    fire(0, 4'd0, 1'b1, 5'd7, 3'd1);
    repeat (300) @(negedge clk);
    verify(0, 1'b1, "R10 start offset ignored");
  endtask

  task automatic t_reset_mid();
    clr();
    fire(2, 4'd0, 1'b1, 5'd0, 3'd1);
    repeat (40) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(busy0 == 0 && we0 == 0 && idx0 == 0, "R1 reset mid-load", {busy0, we0, idx0}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    clr();
    repeat (10) @(negedge clk);
    chk(bcnt0 == 0 && wcnt0 == 0, "R1 idle after reset", bcnt0 + wcnt0, 0);
  endtask

  bit done = 1'b0;

  initial begin
    for (int k = 0; k < 1024; k++) vram[k] = 32'hA5000000 | (32'(k) << 12) | 32'(k * 7);
    t_reset();
    t_linear(0);
    t_linear(3);
    t_grid(0);
    t_grid(2);
    t_bad_ctrl();
    t_bad_fmt();
    t_retrigger();
    t_start();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule